// File: doc/BRIEF.md
# Indexed display-controller register port

This block is the host-facing register file of a display controller. Software reaches every register through two 32-bit ports. It first writes a register number to the index port, then reads or writes the selected register through the value port. A third, vestigial firmware port returns a fixed word on reads and ignores writes. The register file holds:

- the display mode (enable, width, height, colour depth and the masks derived from it);
- the capability bits;
- the command-ring setup;
- the cursor state;
- a bank of general scratch words.

Several value-port writes do more than store a word. A write to the identity register is accepted only for one of three legal revision codes. Writing the enable register invalidates the current geometry and latches the framebuffer size. Configure-done is granted only when the four command-ring header words, supplied on input ports, describe a legal ring. A sync request raises a busy flag and pulses a start request to the command processor, and the flag drops once the processor reports the ring empty.

Read data is registered: a read issued in one cycle appears on `rdata_o` after the next rising clock edge and holds until the next read.

Top module: `disp_regport`

## Requirements
- R1: After reset the register file holds the following values. Identity (index 0) is 0x90000002. The index port reads 0. Enable (index 1), configure-done (index 20) and cursor-visible (index 27) read 0. Depth (index 6) reads 24. The colour masks at indices 9, 10 and 11 read 0x00FF0000, 0x0000FF00 and 0x000000FF.
- R2: A value-port write to index 0 is stored only when the value is 0x90000000, 0x90000001 or 0x90000002. Any other value leaves index 0 unchanged.
- R3: A write to index 1 stores the value, and its other effects are as follows:
  - The current width (index 2) and height (index 3) become 0xFFFFFFFF.
  - A zero value clears configure-done.
  - A nonzero value latches 3 × pending width × pending height into the framebuffer-size register (index 16).
  - Writes to index 2 or 3 set both the pending and the current dimension.
- R4: The following registers are derived:
  - Indices 7 and 28 read 24.
  - Index 12 reads 3 × pending width.
  - Index 4 reads 2360 and index 5 reads 1770.
  - Index 17 reads 0x3, or 0xE3 when `cursor_hw_i` is high (rect-fill bit 0, rect-copy bit 1, cursor bits 5 to 7).
- R5: A nonzero write to index 20 sets configure-done only when all four ring header words are multiples of 4, min ≥ 16, max ≤ 0x10000 and max ≥ min + 10240. Otherwise the flag keeps its value. A zero write clears it.
- R6: A write to index 21 sets the busy flag and pulses `sync_start_o` high for the following cycle. Reads of index 21 or 22 return the busy flag. The flag clears on the first edge, after the pulse, at which `ring_empty_i` is high.
- R7: A write to index 27 behaves according to its value:
  - 1 makes the cursor visible.
  - 0 hides it.
  - Any other value leaves visibility unchanged.
  - Indices 24, 25 and 26 store and read back the cursor id, x and y.
- R8: Scratch words occupy indices 1792 to 1792+SCRATCH_WORDS-1 and read back what was written. Indices 30 to 32 and 1024 to 1791 read 0, ignore writes and do not raise `bad_reg_o`.
- R9: Reads of the firmware port (select 2) return 0x0000CAFE. Writes to it change nothing.
- R10: A value-port read of an unmapped index returns 0 and raises `bad_reg_o` for the cycle in which that data is presented. A read of a mapped index leaves `bad_reg_o` low.
- R11: A write to index 6 or 7 with a value other than the current depth clears configure-done. A write equal to the depth leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_sel_i | input | 2 | Port select: 0 index, 1 value, 2 firmware |
| wr_i | input | 1 | Write strobe for the selected port |
| rd_i | input | 1 | Read strobe for the selected port |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| bad_reg_o | output | 1 | Unmapped-index read flag |
| ring_min_i | input | 32 | Ring header: lower bound in bytes |
| ring_max_i | input | 32 | Ring header: upper bound in bytes |
| ring_next_i | input | 32 | Ring header: producer offset |
| ring_stop_i | input | 32 | Ring header: consumer offset |
| cursor_hw_i | input | 1 | Cursor support present |
| ring_empty_i | input | 1 | Command processor reports ring drained |
| sync_start_o | output | 1 | One-cycle start request to the command processor |

## Verification
The ring-header check is tested at its exact edges: spans of 10236 and 10240, max of 0x10000 and 0x10004, min of 12 and 16, and a misaligned producer or consumer word. A check using the wrong comparison direction or a missing term would grant or refuse configure-done on the wrong side of one of these edges. A failed check that still wrote the flag would drop an already granted configure-done, and that case is tested too.

Identity writes with random illegal values, and cursor-visible writes of 2, 3 and 4, must leave the register untouched. Busy is read both before and after `ring_empty_i` rises, so an early clear or a flag that sticks would show.

Scratch hits at the first and last word, together with the word just past the bank, show off-by-one decoding. That decoding error would either alias the bank or miss the `bad_reg_o` flag.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam logic [1:0] PORT_INDEX = 2'd0;
  localparam logic [1:0] PORT_VALUE = 2'd1;
  localparam logic [1:0] PORT_FW    = 2'd2;

  localparam logic [31:0] IX_ID      = 32'd0;
  localparam logic [31:0] IX_ENABLE  = 32'd1;
  localparam logic [31:0] IX_WIDTH   = 32'd2;
  localparam logic [31:0] IX_HEIGHT  = 32'd3;
  localparam logic [31:0] IX_MAXW    = 32'd4;
  localparam logic [31:0] IX_MAXH    = 32'd5;
  localparam logic [31:0] IX_DEPTH   = 32'd6;
  localparam logic [31:0] IX_BPP     = 32'd7;
  localparam logic [31:0] IX_PSEUDO  = 32'd8;
  localparam logic [31:0] IX_RMASK   = 32'd9;
  localparam logic [31:0] IX_GMASK   = 32'd10;
  localparam logic [31:0] IX_BMASK   = 32'd11;
  localparam logic [31:0] IX_PITCH   = 32'd12;
  localparam logic [31:0] IX_FBBASE  = 32'd13;
  localparam logic [31:0] IX_FBOFS   = 32'd14;
  localparam logic [31:0] IX_VRAM    = 32'd15;
  localparam logic [31:0] IX_FBSIZE  = 32'd16;
  localparam logic [31:0] IX_CAPS    = 32'd17;
  localparam logic [31:0] IX_RBASE   = 32'd18;
  localparam logic [31:0] IX_RSIZE   = 32'd19;
  localparam logic [31:0] IX_CFGDONE = 32'd20;
  localparam logic [31:0] IX_SYNC    = 32'd21;
  localparam logic [31:0] IX_BUSY    = 32'd22;
  localparam logic [31:0] IX_GUEST   = 32'd23;
  localparam logic [31:0] IX_CUR_ID  = 32'd24;
  localparam logic [31:0] IX_CUR_X   = 32'd25;
  localparam logic [31:0] IX_CUR_Y   = 32'd26;
  localparam logic [31:0] IX_CUR_VIS = 32'd27;
  localparam logic [31:0] IX_HOSTBPP = 32'd28;
  localparam logic [31:0] IX_SCRSIZE = 32'd29;
  localparam logic [31:0] IX_RSV_LO  = 32'd30;
  localparam logic [31:0] IX_RSV_HI  = 32'd32;
  localparam logic [31:0] IX_PAL_LO  = 32'd1024;
  localparam logic [31:0] IX_PAL_HI  = 32'd1791;
  localparam logic [31:0] IX_SCR_LO  = 32'd1792;

  localparam logic [31:0] ID_REV0 = 32'h9000_0000;
  localparam logic [31:0] ID_REV1 = 32'h9000_0001;
  localparam logic [31:0] ID_REV2 = 32'h9000_0002;

  localparam logic [31:0] FW_WORD    = 32'h0000_CAFE;
  localparam logic [31:0] MAX_WIDTH  = 32'd2360;
  localparam logic [31:0] MAX_HEIGHT = 32'd1770;
  localparam logic [31:0] RING_BYTES = 32'h0001_0000;
  localparam logic [31:0] RING_FLOOR = 32'd16;
  localparam logic [31:0] RING_SPAN  = 32'd10240;

  localparam logic [31:0] CAP_FILL   = 32'h0000_0001;
  localparam logic [31:0] CAP_COPY   = 32'h0000_0002;
  localparam logic [31:0] CAP_CURSOR = 32'h0000_00E0;

  localparam logic [31:0] MASK_RED   = 32'h00FF_0000;
  localparam logic [31:0] MASK_GREEN = 32'h0000_FF00;
  localparam logic [31:0] MASK_BLUE  = 32'h0000_00FF;
endpackage

// File: rtl/regport_ring_check.sv
module regport_ring_check
  import regport_pkg::*;
(
  input  logic [31:0] min_i,
  input  logic [31:0] max_i,
  input  logic [31:0] next_i,
  input  logic [31:0] stop_i,
  output logic        ok_o
);
  logic        aligned, floor_ok, ceil_ok, span_ok;
  logic [32:0] lo_plus_span;

  always_comb begin
    aligned      = ((min_i | max_i | next_i | stop_i) & 32'd3) == 32'd0;
    floor_ok     = min_i >= RING_FLOOR;
    ceil_ok      = max_i <= RING_BYTES;
    lo_plus_span = {1'b0, min_i} + {1'b0, RING_SPAN};
    span_ok      = {1'b0, max_i} >= lo_plus_span;
    ok_o         = aligned & floor_ok & ceil_ok & span_ok;
  end
endmodule

// File: rtl/regport_scratch.sv
module regport_scratch #(
  parameter int unsigned WORDS = 256,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/regport_sync.sv
module regport_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic empty_i,
  output logic busy_o,
  output logic start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      start_o <= 1'b0;
    end else begin
      start_o <= set_i;
      if (set_i)                          busy_o <= 1'b1;
      else if (busy_o && empty_i && !start_o) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/disp_regport.sv
module disp_regport
  import regport_pkg::*;
#(
  parameter int unsigned SCRATCH_WORDS = 256,
  parameter int unsigned DEPTH         = 24,
  parameter logic [31:0] FB_BASE       = 32'hE000_0000,
  parameter logic [31:0] VRAM_BYTES    = 32'h0100_0000,
  parameter logic [31:0] RING_BASE     = 32'hE100_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  port_sel_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        bad_reg_o,
  input  logic [31:0] ring_min_i,
  input  logic [31:0] ring_max_i,
  input  logic [31:0] ring_next_i,
  input  logic [31:0] ring_stop_i,
  input  logic        cursor_hw_i,
  input  logic        ring_empty_i,
  output logic        sync_start_o
);
  localparam int unsigned SAW      = $clog2(SCRATCH_WORDS);
  localparam logic [31:0] BYTES_PP = 32'((DEPTH + 7) / 8);
  localparam logic [31:0] BPP_RND  = 32'(((DEPTH + 7) / 8) * 8);
  localparam logic [31:0] DEPTH_W  = 32'(DEPTH);
  localparam logic [31:0] SCR_N    = 32'(SCRATCH_WORDS);

  logic [31:0] index_q, id_q, enable_q, width_q, height_q, new_w_q, new_h_q;
  logic [31:0] fb_size_q, guest_q, cur_id_q, cur_x_q, cur_y_q;
  logic        config_q, cur_on_q;
  logic        wr_val, rd_val, cfg_ok, syncing, scr_hit, is_zero_reg;
  logic [31:0] scr_ofs, scr_rdata, rd_word, fb_calc;
  logic        rd_bad;

  assign wr_val  = wr_i && (port_sel_i == PORT_VALUE);
  assign rd_val  = rd_i && (port_sel_i == PORT_VALUE);
  assign scr_ofs = index_q - IX_SCR_LO;
  assign scr_hit = (index_q >= IX_SCR_LO) && (scr_ofs < SCR_N);
  assign is_zero_reg = ((index_q >= IX_RSV_LO) && (index_q <= IX_RSV_HI)) ||
                       ((index_q >= IX_PAL_LO) && (index_q <= IX_PAL_HI));
  assign fb_calc = BYTES_PP * new_w_q * new_h_q;

  regport_ring_check u_ring_check (
    .min_i (ring_min_i), .max_i (ring_max_i),
    .next_i(ring_next_i), .stop_i(ring_stop_i), .ok_o(cfg_ok)
  );

  regport_scratch #(.WORDS(SCRATCH_WORDS)) u_scratch (
    .clk_i  (clk_i),
    .we_i   (wr_val && scr_hit),
    .addr_i (scr_ofs[SAW-1:0]),
    .wdata_i(wdata_i),
    .rdata_o(scr_rdata)
  );

  regport_sync u_sync (
    .clk_i  (clk_i), .rst_ni(rst_ni),
    .set_i  (wr_val && (index_q == IX_SYNC)),
    .empty_i(ring_empty_i),
    .busy_o (syncing), .start_o(sync_start_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0; id_q <= ID_REV2; enable_q <= '0;
      width_q <= '1; height_q <= '1; new_w_q <= '0; new_h_q <= '0;
      fb_size_q <= '0; config_q <= 1'b0; guest_q <= '0;
      cur_id_q <= '0; cur_x_q <= '0; cur_y_q <= '0; cur_on_q <= 1'b0;
    end else begin
      if (wr_i && port_sel_i == PORT_INDEX) index_q <= wdata_i;
      if (wr_val) begin
        case (index_q)
          IX_ID: if (wdata_i == ID_REV0 || wdata_i == ID_REV1 || wdata_i == ID_REV2)
                   id_q <= wdata_i;
          IX_ENABLE: begin
            enable_q <= wdata_i;
            width_q  <= '1;
            height_q <= '1;
            if (wdata_i == '0) config_q  <= 1'b0;
            else               fb_size_q <= fb_calc;
          end
          IX_WIDTH:  begin new_w_q <= wdata_i; width_q  <= wdata_i; end
          IX_HEIGHT: begin new_h_q <= wdata_i; height_q <= wdata_i; end
          IX_DEPTH, IX_BPP: if (wdata_i != DEPTH_W) config_q <= 1'b0;
          IX_CFGDONE: begin
            if (wdata_i == '0) config_q <= 1'b0;
            else if (cfg_ok)   config_q <= 1'b1;
          end
          IX_GUEST:   guest_q  <= wdata_i;
          IX_CUR_ID:  cur_id_q <= wdata_i;
          IX_CUR_X:   cur_x_q  <= wdata_i;
          IX_CUR_Y:   cur_y_q  <= wdata_i;
          IX_CUR_VIS: begin
            if (wdata_i == 32'd1)      cur_on_q <= 1'b1;
            else if (wdata_i == 32'd0) cur_on_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_bad  = 1'b0;
    rd_word = '0;
    case (index_q)
      IX_ID:      rd_word = id_q;
      IX_ENABLE:  rd_word = enable_q;
      IX_WIDTH:   rd_word = width_q;
      IX_HEIGHT:  rd_word = height_q;
      IX_MAXW:    rd_word = MAX_WIDTH;
      IX_MAXH:    rd_word = MAX_HEIGHT;
      IX_DEPTH:   rd_word = DEPTH_W;
      IX_BPP, IX_HOSTBPP: rd_word = BPP_RND;
      IX_PSEUDO, IX_FBOFS: rd_word = '0;
      IX_RMASK:   rd_word = MASK_RED;
      IX_GMASK:   rd_word = MASK_GREEN;
      IX_BMASK:   rd_word = MASK_BLUE;
      IX_PITCH:   rd_word = BYTES_PP * new_w_q;
      IX_FBBASE:  rd_word = FB_BASE;
      IX_VRAM:    rd_word = VRAM_BYTES;
      IX_FBSIZE:  rd_word = fb_size_q;
      IX_CAPS:    rd_word = CAP_FILL | CAP_COPY | (cursor_hw_i ? CAP_CURSOR : '0);
      IX_RBASE:   rd_word = RING_BASE;
      IX_RSIZE:   rd_word = RING_BYTES;
      IX_CFGDONE: rd_word = {31'd0, config_q};
      IX_SYNC, IX_BUSY: rd_word = {31'd0, syncing};
      IX_GUEST:   rd_word = guest_q;
      IX_CUR_ID:  rd_word = cur_id_q;
      IX_CUR_X:   rd_word = cur_x_q;
      IX_CUR_Y:   rd_word = cur_y_q;
      IX_CUR_VIS: rd_word = {31'd0, cur_on_q};
      IX_SCRSIZE: rd_word = SCR_N;
      default: begin
        if (scr_hit)           rd_word = scr_rdata;
        else if (!is_zero_reg) rd_bad  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      bad_reg_o <= 1'b0;
    end else begin
      bad_reg_o <= rd_val && rd_bad;
      if (rd_i) begin
        case (port_sel_i)
          PORT_INDEX: rdata_o <= index_q;
          PORT_VALUE: rdata_o <= rd_word;
          PORT_FW:    rdata_o <= FW_WORD;
          default:    rdata_o <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/regport_chk.sv
module regport_chk
  import regport_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  port_sel_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [31:0] wdata_i,
  input logic [31:0] index_q,
  input logic [31:0] id_q,
  input logic        config_q,
  input logic        cfg_ok,
  input logic        cur_on_q,
  input logic        syncing,
  input logic        sync_start_o,
  input logic        bad_reg_o
);
  logic wv;
  assign wv = wr_i && (port_sel_i == PORT_VALUE);

  a_r2_id_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wv && index_q == IX_ID && wdata_i != ID_REV0 && wdata_i != ID_REV1 && wdata_i != ID_REV2)
    |=> $stable(id_q));

  a_r5_cfg_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(config_q) |-> $past(wv && index_q == IX_CFGDONE && wdata_i != '0 && cfg_ok));

  a_r6_sync_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wv && index_q == IX_SYNC) |=> (syncing && sync_start_o));

  a_r6_start_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_start_o |-> $past(wv && index_q == IX_SYNC));

  a_r7_cursor_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wv && index_q == IX_CUR_VIS && wdata_i > 32'd1) |=> $stable(cur_on_q));

  a_r10_bad_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_reg_o |-> $past(rd_i && port_sel_i == PORT_VALUE));
endmodule

bind disp_regport regport_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .port_sel_i  (port_sel_i),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .wdata_i     (wdata_i),
  .index_q     (index_q),
  .id_q        (id_q),
  .config_q    (config_q),
  .cfg_ok      (cfg_ok),
  .cur_on_q    (cur_on_q),
  .syncing     (syncing),
  .sync_start_o(sync_start_o),
  .bad_reg_o   (bad_reg_o)
);

// File: tb/test_disp_regport.sv
`timescale 1ns/1ps
module test_disp_regport;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [1:0]  port_sel = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        bad, start;
  logic [31:0] r_min = '0, r_max = '0, r_next = '0, r_stop = '0;
  logic        cur_hw = 1'b0, r_empty = 1'b0;
  int n_chk = 0, n_fail = 0;
  logic        last_bad;

  always #2.5 clk = ~clk;

  disp_regport i_disp_regport (
    .clk_i(clk), .rst_ni(rst_ni), .port_sel_i(port_sel), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .bad_reg_o(bad),
    .ring_min_i(r_min), .ring_max_i(r_max), .ring_next_i(r_next), .ring_stop_i(r_stop),
    .cursor_hw_i(cur_hw), .ring_empty_i(r_empty), .sync_start_o(start)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic port_wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); port_sel = s; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic port_rd(input logic [1:0] s, output logic [31:0] q);
    @(negedge clk); port_sel = s; rd = 1'b1;
    @(negedge clk); rd = 1'b0; q = rdata; last_bad = bad;
  endtask

  task automatic reg_wr(input logic [31:0] idx, input logic [31:0] v);
    port_wr(2'd0, idx); port_wr(2'd1, v);
  endtask

  task automatic reg_rd(input logic [31:0] idx, output logic [31:0] q);
    port_wr(2'd0, idx); port_rd(2'd1, q);
  endtask

  function automatic logic id_legal(input logic [31:0] v);
    return v == 32'h9000_0000 || v == 32'h9000_0001 || v == 32'h9000_0002;
  endfunction

  function automatic logic ring_ok(input logic [31:0] mn, mx, nx, st);
    return (((mn | mx | nx | st) & 32'd3) == 0) && mn >= 16 && mx <= 32'h10000 &&
           ({1'b0, mx} >= {1'b0, mn} + 33'd10240);
  endfunction

  task automatic set_ring(input logic [31:0] mn, mx, nx, st);
    r_min = mn; r_max = mx; r_next = nx; r_stop = st;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] q, exp_id;
    logic        exp_on;
    logic [31:0] s_val [12];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    port_rd(2'd0, q); chk("R1 index", q, 32'd0);
    reg_rd(0, q);  chk("R1 id", q, 32'h9000_0002);
    reg_rd(1, q);  chk("R1 enable", q, 0);
    reg_rd(20, q); chk("R1 config", q, 0);
    reg_rd(27, q); chk("R1 cursor", q, 0);
    reg_rd(6, q);  chk("R1 depth", q, 24);
    reg_rd(9, q);  chk("R1 red", q, 32'h00FF_0000);
    reg_rd(10, q); chk("R1 green", q, 32'h0000_FF00);
    reg_rd(11, q); chk("R1 blue", q, 32'h0000_00FF);

    // R2 identity negotiation
    exp_id = 32'h9000_0002;
    for (int k = 0; k < 24; k++) begin
      int r; logic [31:0] v;
      r = int'($urandom % 4);
      v = (r < 3) ? 32'h9000_0000 + 32'(r) : $urandom;
      if (k == 5) v = 32'h9000_0003;
      if (id_legal(v)) exp_id = v;
      reg_wr(0, v); reg_rd(0, q); chk("R2 id", q, exp_id);
    end

    // R4 derived registers
    reg_rd(7, q);  chk("R4 bpp", q, 24);
    reg_rd(28, q); chk("R4 host bpp", q, 24);
    reg_rd(4, q);  chk("R4 max width", q, 2360);
    reg_rd(5, q);  chk("R4 max height", q, 1770);
    reg_rd(17, q); chk("R4 caps no cursor", q, 32'h3);
    cur_hw = 1'b1;
    reg_rd(17, q); chk("R4 caps cursor", q, 32'hE3);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] w;
      w = $urandom % 4096;
      reg_wr(2, w); reg_rd(12, q); chk("R4 pitch", q, 3 * w);
      reg_rd(2, q); chk("R3 width write", q, w);
    end

    // R5 ring header check, directed edges
    set_ring(16, 16 + 10240, 0, 0);
    reg_wr(20, 0); reg_wr(20, 1); reg_rd(20, q); chk("R5 exact span", q, 1);
    set_ring(16, 16 + 10236, 0, 0);
    reg_wr(20, 1); reg_rd(20, q); chk("R5 fail keeps set", q, 1);
    reg_wr(20, 0); reg_wr(20, 1); reg_rd(20, q); chk("R5 short span", q, 0);
    set_ring(12, 32'h10000, 0, 0);
    reg_wr(20, 1); reg_rd(20, q); chk("R5 min floor", q, 0);
    set_ring(16, 32'h10004, 0, 0);
    reg_wr(20, 1); reg_rd(20, q); chk("R5 max ceiling", q, 0);
    set_ring(16, 32'h10000, 6, 0);
    reg_wr(20, 1); reg_rd(20, q); chk("R5 misaligned", q, 0);
    set_ring(16, 32'h10000, 8, 4);
    reg_wr(20, 1); reg_rd(20, q); chk("R5 max exact", q, 1);
    for (int k = 0; k < 40; k++) begin
      logic [31:0] mn, mx, nx, st;
      mn = ($urandom % 2) ? 32'(($urandom % 40) * 4) : 32'($urandom % 200);
      mx = mn + 32'd10232 + 32'(($urandom % 5) * 4);
      if ($urandom % 5 == 0) mx = 32'h10000 + 32'(($urandom % 3) * 4) - 32'd4;
      nx = 32'(($urandom % 8) * 4) + (($urandom % 6 == 0) ? 32'd1 : 32'd0);
      st = 32'(($urandom % 8) * 4) + (($urandom % 6 == 0) ? 32'd2 : 32'd0);
      set_ring(mn, mx, nx, st);
      reg_wr(20, 0); reg_wr(20, 1); reg_rd(20, q);
      chk("R5 random header", q, {31'd0, ring_ok(mn, mx, nx, st)});
    end

    // R11 depth writes
    set_ring(16, 32'h10000, 0, 0);
    reg_wr(20, 1);
    reg_wr(6, 24); reg_rd(20, q); chk("R11 equal depth keeps", q, 1);
    reg_wr(7, 16); reg_rd(20, q); chk("R11 mismatch clears", q, 0);

    // R3 enable
    reg_wr(20, 1);
    reg_wr(2, 640); reg_wr(3, 480); reg_wr(1, 1);
    reg_rd(1, q);  chk("R3 enable stored", q, 1);
    reg_rd(16, q); chk("R3 fb size", q, 32'd921600);
    reg_rd(2, q);  chk("R3 width invalid", q, 32'hFFFF_FFFF);
    reg_rd(3, q);  chk("R3 height invalid", q, 32'hFFFF_FFFF);
    reg_rd(20, q); chk("R3 nonzero keeps config", q, 1);
    reg_wr(2, 10); reg_wr(1, 0);
    reg_rd(20, q); chk("R3 disable clears config", q, 0);
    reg_rd(16, q); chk("R3 fb size held on disable", q, 32'd921600);

    // R6 sync / busy
    r_empty = 1'b0;
    reg_wr(21, 1);
    chk("R6 start pulse", {31'd0, start}, 1);
    @(negedge clk); chk("R6 start one cycle", {31'd0, start}, 0);
    reg_rd(22, q); chk("R6 busy held", q, 1);
    reg_rd(21, q); chk("R6 sync reads busy", q, 1);
    r_empty = 1'b1;
    @(negedge clk);
    reg_rd(22, q); chk("R6 busy cleared", q, 0);
    r_empty = 1'b0;

    // R7 cursor
    exp_on = 1'b0;
    for (int k = 0; k < 20; k++) begin
      logic [31:0] v;
      v = $urandom % 5;
      if (v == 0) exp_on = 1'b0; else if (v == 1) exp_on = 1'b1;
      reg_wr(27, v); reg_rd(27, q); chk("R7 cursor visible", q, {31'd0, exp_on});
    end
    reg_wr(25, 32'd123); reg_wr(26, 32'd456); reg_wr(24, 32'd7);
    reg_rd(25, q); chk("R7 cursor x", q, 123);
    reg_rd(26, q); chk("R7 cursor y", q, 456);
    reg_rd(24, q); chk("R7 cursor id", q, 7);

    // R8 scratch and zero regions
    for (int k = 0; k < 12; k++) begin
      s_val[k] = $urandom;
      reg_wr(1792 + 32'(k * 21), s_val[k]);
    end
    reg_wr(2047, 32'hA5A5_0001);
    for (int k = 0; k < 12; k++) begin
      reg_rd(1792 + 32'(k * 21), q); chk("R8 scratch", q, s_val[k]);
    end
    reg_rd(2047, q); chk("R8 scratch last", q, 32'hA5A5_0001);
    chk("R8 scratch no bad", {31'd0, last_bad}, 0);
    reg_wr(1100, 32'h1234); reg_rd(1100, q); chk("R8 palette zero", q, 0);
    chk("R8 palette no bad", {31'd0, last_bad}, 0);
    reg_wr(31, 32'h55); reg_rd(31, q); chk("R8 reserved zero", q, 0);
    reg_rd(29, q); chk("R8 scratch size", q, 256);

    // R9 firmware port
    port_wr(2'd0, 32'd5);
    port_wr(2'd2, 32'h1234_5678);
    port_rd(2'd2, q); chk("R9 fw read", q, 32'h0000_CAFE);
    port_rd(2'd0, q); chk("R9 fw write ignored", q, 5);

    // R10 unmapped
    reg_rd(40, q);   chk("R10 unmapped data", q, 0);
    chk("R10 bad flag", {31'd0, last_bad}, 1);
    @(negedge clk);  chk("R10 bad one cycle", {31'd0, bad}, 0);
    reg_rd(2048, q); chk("R10 past scratch", {31'd0, last_bad}, 1);
    reg_rd(0, q);    chk("R10 mapped no bad", {31'd0, last_bad}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule